// File: doc/BRIEF.md
# Linked Activity/Inactivity Sleep Sequencer

This block sits after the motion detectors of a sensor front end. Each clock cycle it may receive a single-cycle activity detection and a single-cycle inactivity detection. It turns these into two sticky interrupt flags and an asleep status bit. The threshold and timing logic that produce the detections lie outside the block.

When the link enable is low, the two detections set their own flags with no ordering between them. When the link enable is high, the block alternates strictly between two states. In the first it watches only for inactivity; in the second it watches only for activity. This way the host is interrupted once per motion/rest transition and not on every busy sample. The host clears both flags by reading its interrupt source, which reaches the block as a one-cycle clear strobe. With autosleep enabled, an accepted inactivity puts the block to sleep, provided no activity interrupt is still waiting to be cleared. The next accepted activity wakes it.

Top module: `link_sleep_seq`

## Requirements
- R1: After synchronous reset, act_irq, inact_irq and asleep are 0, and in linked mode the sequencer first accepts only inactivity.
- R2: With link_en low, act_det high sets act_irq and inact_det high sets inact_irq on the next clock edge, each on its own. An accepted detection is one that takes effect.
- R3: With link_en high, act_det is ignored (act_irq does not set) until an inactivity has been accepted. After that, inact_det is ignored until an activity has been accepted. Clearing link_en returns the sequencer to the inactivity-first state.
- R4: clr high clears both flags on the next clock edge unless R5 applies.
- R5: An accepted detection in the same cycle as clr leaves its flag set.
- R6: An accepted inactivity with autosleep_en high and act_irq low sets asleep on the next clock edge.
- R7: While act_irq is high, asleep does not go from 0 to 1.
- R8: An accepted activity clears asleep on the next clock edge. autosleep_en low also clears asleep on the next clock edge.
- R9: All outputs are registered. An input affects them only at the following rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Enables strict inactivity/activity alternation |
| autosleep_en | input | 1 | Allows entry into sleep on inactivity |
| act_det | input | 1 | Activity detection pulse |
| inact_det | input | 1 | Inactivity detection pulse |
| clr | input | 1 | Host read of the interrupt source; clears both flags |
| act_irq | output | 1 | Sticky activity interrupt flag |
| inact_irq | output | 1 | Sticky inactivity interrupt flag |
| asleep | output | 1 | Block is in the asleep state |

## Verification
Random streams of detections are run with link_en held low and with link_en held high. Comparing the two separates the independent flag setting from the alternation, and repeated same-kind detections in linked mode show that they are ignored. Clear strobes placed on, before and after detections separate clear priority from set priority. Inactivity that arrives while an uncleared activity flag is pending, and autosleep toggled mid-run, show the sleep gating apart from the plain sleep entry and wake.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic {
    ARM_INACT = 1'b0,
    ARM_ACT   = 1'b1
  } arm_e;

  localparam int FLAG_ACT   = 0;
  localparam int FLAG_INACT = 1;
  localparam int NUM_FLAGS  = 2;
endpackage

// File: rtl/lss_arm.sv
module lss_arm
  import lss_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic link_en,
  input  logic act_det,
  input  logic inact_det,
  output arm_e arm_q,
  output logic act_acc,
  output logic inact_acc
);
  arm_e arm_d;

  always_comb begin
    arm_d = arm_q;
    if (!link_en) begin
      act_acc   = act_det;
      inact_acc = inact_det;
      arm_d     = ARM_INACT;
    end else begin
      act_acc   = act_det   && (arm_q == ARM_ACT);
      inact_acc = inact_det && (arm_q == ARM_INACT);
      if (inact_acc) arm_d = ARM_ACT;
      else if (act_acc) arm_d = ARM_INACT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) arm_q <= ARM_INACT;
    else     arm_q <= arm_d;
  end
endmodule

// File: rtl/lss_flag.sv
module lss_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/lss_sleep.sv
module lss_sleep (
  input  logic clk,
  input  logic rst,
  input  logic autosleep_en,
  input  logic act_acc,
  input  logic inact_acc,
  input  logic act_pend,
  output logic asleep_q
);
  logic asleep_d;

  always_comb begin
    asleep_d = asleep_q;
    if (!autosleep_en || act_acc)      asleep_d = 1'b0;
    else if (inact_acc && !act_pend)   asleep_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) asleep_q <= 1'b0;
    else     asleep_q <= asleep_d;
  end
endmodule

// File: rtl/link_sleep_seq.sv
module link_sleep_seq
  import lss_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic link_en,
  input  logic autosleep_en,
  input  logic act_det,
  input  logic inact_det,
  input  logic clr,
  output logic act_irq,
  output logic inact_irq,
  output logic asleep
);
  arm_e arm_q;
  logic act_acc, inact_acc;
  logic [NUM_FLAGS-1:0] flag_set, flag_q;

  lss_arm u_arm (
    .clk(clk), .rst(rst), .link_en(link_en),
    .act_det(act_det), .inact_det(inact_det),
    .arm_q(arm_q), .act_acc(act_acc), .inact_acc(inact_acc)
  );

  assign flag_set[FLAG_ACT]   = act_acc;
  assign flag_set[FLAG_INACT] = inact_acc;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    lss_flag u_flag (
      .clk(clk), .rst(rst), .set(flag_set[i]), .clr(clr), .q(flag_q[i])
    );
  end

  lss_sleep u_sleep (
    .clk(clk), .rst(rst), .autosleep_en(autosleep_en),
    .act_acc(act_acc), .inact_acc(inact_acc),
    .act_pend(flag_q[FLAG_ACT]), .asleep_q(asleep)
  );

  assign act_irq   = flag_q[FLAG_ACT];
  assign inact_irq = flag_q[FLAG_INACT];
endmodule

// File: rtl/lss_checker.sv
module lss_checker
  import lss_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic link_en,
  input logic autosleep_en,
  input logic act_det,
  input logic inact_det,
  input logic clr,
  input logic act_irq,
  input logic inact_irq,
  input logic asleep,
  input arm_e arm_q
);
  // R3: activity is ignored while the sequencer waits for inactivity
  p_link_ignore_act_r3: assert property (@(posedge clk) disable iff (rst)
    (link_en && arm_q == ARM_INACT && !act_irq) |=> !act_irq);

  // R4: clear with no detection empties both flags
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr && !act_det && !inact_det) |=> (!act_irq && !inact_irq));

  // R2 and R5: unlinked activity always sets the flag, even with clear
  p_unlinked_set_r5: assert property (@(posedge clk) disable iff (rst)
    (!link_en && act_det) |=> act_irq);

  // R7: no sleep entry while activity is pending
  p_no_sleep_pending_r7: assert property (@(posedge clk) disable iff (rst)
    (!asleep && act_irq) |=> !asleep);

  // R8: autosleep off forces awake
  p_autosleep_off_r8: assert property (@(posedge clk) disable iff (rst)
    !autosleep_en |=> !asleep);

  // R8: accepted activity wakes
  p_wake_r8: assert property (@(posedge clk) disable iff (rst)
    (act_det && (!link_en || arm_q == ARM_ACT)) |=> !asleep);
endmodule

bind link_sleep_seq lss_checker u_chk (
  .clk(clk), .rst(rst), .link_en(link_en), .autosleep_en(autosleep_en),
  .act_det(act_det), .inact_det(inact_det), .clr(clr),
  .act_irq(act_irq), .inact_irq(inact_irq), .asleep(asleep), .arm_q(arm_q)
);

// File: tb/link_sleep_seq_bench.sv
module link_sleep_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 4000;

  logic clk = 1'b0;
  logic rst, link_en, autosleep_en, act_det, inact_det, clr;
  logic act_irq, inact_irq, asleep;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  bit m_wait_act, m_act, m_inact, m_sleep;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_sleep_seq u_link_sleep_seq (
    .clk(clk), .rst(rst), .link_en(link_en), .autosleep_en(autosleep_en),
    .act_det(act_det), .inact_det(inact_det), .clr(clr),
    .act_irq(act_irq), .inact_irq(inact_irq), .asleep(asleep)
  );

  task automatic check(input string req, input string what, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, got, exp, $time);
    end
  endtask

  // advance reference model by one clock from the inputs being driven
  task automatic model_step();
    bit aa, ia;
    if (rst) begin
      m_wait_act = 0; m_act = 0; m_inact = 0; m_sleep = 0;
      return;
    end
    if (!link_en) begin
      aa = act_det; ia = inact_det;
    end else begin
      aa = act_det && m_wait_act;
      ia = inact_det && !m_wait_act;
    end
    if (!autosleep_en || aa) m_sleep = 0;
    else if (ia && !m_act)   m_sleep = 1;
    m_act   = aa ? 1'b1 : (clr ? 1'b0 : m_act);
    m_inact = ia ? 1'b1 : (clr ? 1'b0 : m_inact);
    if (!link_en) m_wait_act = 0;
    else if (ia)  m_wait_act = 1;
    else if (aa)  m_wait_act = 0;
  endtask

  // drive at negedge, clock, compare just after the edge
  task automatic cyc(input bit l, input bit a, input bit ad, input bit id, input bit c,
                     input string req);
    @(negedge clk);
    link_en = l; autosleep_en = a; act_det = ad; inact_det = id; clr = c;
    model_step();
    @(posedge clk); #1;
    check(req, "act_irq", act_irq, m_act);
    check(req, "inact_irq", inact_irq, m_inact);
    check(req, "asleep", asleep, m_sleep);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; link_en = 0; autosleep_en = 0; act_det = 0; inact_det = 0; clr = 0;
    m_wait_act = 0; m_act = 0; m_inact = 0; m_sleep = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check("R1", "reset act_irq", act_irq, 1'b0);
    check("R1", "reset inact_irq", inact_irq, 1'b0);
    check("R1", "reset asleep", asleep, 1'b0);

    // R1/R3: linked, activity first is ignored
    cyc(1, 1, 1, 0, 0, "R3");
    check("R1", "act ignored before inactivity", act_irq, 1'b0);
    // R6: inactivity accepted, sleep entered
    cyc(1, 1, 0, 1, 0, "R6");
    check("R6", "sleep entry", asleep, 1'b1);
    // R3: second inactivity ignored, clear inact flag then retry
    cyc(1, 1, 0, 0, 1, "R4");
    check("R4", "clear inact", inact_irq, 1'b0);
    cyc(1, 1, 0, 1, 0, "R3");
    check("R3", "inact ignored while waiting activity", inact_irq, 1'b0);
    // R8: activity wakes; R5 with same-cycle clear
    cyc(1, 1, 1, 0, 1, "R5");
    check("R5", "act kept with clear", act_irq, 1'b1);
    check("R8", "wake on activity", asleep, 1'b0);
    // R7: inactivity with pending activity does not sleep
    cyc(1, 1, 0, 1, 0, "R7");
    check("R7", "no sleep while act pending", asleep, 1'b0);
    check("R3", "inact accepted after activity", inact_irq, 1'b1);
    // R8: autosleep off clears asleep
    cyc(1, 1, 0, 0, 1, "R4");
    cyc(1, 1, 1, 0, 0, "R3");
    cyc(1, 1, 0, 0, 1, "R4");
    cyc(1, 1, 0, 1, 0, "R6");
    check("R6", "sleep after clear", asleep, 1'b1);
    cyc(1, 0, 0, 0, 0, "R8");
    check("R8", "autosleep off wakes", asleep, 1'b0);
    // R2: unlinked, both at once
    cyc(0, 1, 1, 1, 1, "R2");
    check("R2", "unlinked act", act_irq, 1'b1);
    check("R2", "unlinked inact", inact_irq, 1'b1);
    // R9: idle cycle holds flags
    cyc(0, 1, 0, 0, 0, "R9");
    check("R9", "flags held when idle", act_irq, 1'b1);

    // random phase, link mode changes in runs
    begin
      bit l = 1;
      for (int i = 0; i < N_RANDOM; i++) begin
        if (($urandom % 100) < 2) l = ~l;
        cyc(l, ($urandom % 100) < 90, ($urandom % 100) < 20,
            ($urandom % 100) < 25, ($urandom % 100) < 15, l ? "R3" : "R2");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule